// File: doc/BRIEF.md
# Tearing-Effect Synchronization Controller

This block lines up a graphics RAM refresh with the scan position of a display that holds its own frame memory. Software, or a higher-level sequencer, arms it once per frame. It then waits for the display to report that its scan has reached the programmed line. When that report arrives, the block raises an interrupt. If auto-refresh was selected at arm time, it also starts the one-shot refresh sequencer in the same cycle.

The display can report the scan line in one of two ways, chosen at arm time:

- **Link mode.** The block requests the tear-enable command (opcode 0x35) from the command path. It then asks for a bus turnaround, so the display owns the link. It waits for the display's trigger byte 0xBA, and the display hands the bus back when it sends that byte.
- **Pin mode.** The block watches a dedicated input through a synchronizer and waits for the chosen edge. Nothing is exchanged over the link in this mode.

A programmable timeout ends a wait that never completes. On a timeout the block sets a sticky error flag. In link mode it also pulses a reclaim request so that the bus is taken back from the display.

Top module: `te_sync_ctrl`

## Requirements
- R1: After reset, busy_o, cmd_req_o, bta_req_o, bus_peer_o, irq_o, refresh_start_o, reclaim_o and err_o are all low.
- R2: An arm in link mode (link_mode_i=1) raises cmd_req_o with cmd_opcode_o=0x35 in the next cycle. cmd_req_o holds until a cycle in which cmd_ack_i is high.
- R3: The cycle after the acknowledge, bta_req_o is high for exactly one cycle. After that, bus_peer_o stays high until the trigger or the timeout. At most one of cmd_req_o, bta_req_o and bus_peer_o is high in any cycle.
- R4: While the block waits in link mode, only rx_valid_i=1 together with rx_byte_i=0xBA counts as the trigger. Any other byte, and 0xBA without rx_valid_i, leaves bus_peer_o high and irq_o low.
- R5: A trigger produces a one-cycle irq_o pulse in the cycle after it. In that same cycle bus_peer_o and busy_o are low.
- R6: An arm in pin mode (link_mode_i=0) issues no command and no turnaround. The active edge on te_pin_i raises irq_o SYNC_STAGES+1 clock edges after the pin changes (3 by default).
- R7: fall_edge_i=0 selects a rising edge of te_pin_i as active, and fall_edge_i=1 selects a falling edge. The opposite edge is ignored.
- R8: Pin edges while the block is idle, or while it waits in link mode, have no effect.
- R9: With timeout_i=T>0 held stable, a wait that gets no trigger lasts exactly T cycles. The block then goes idle with err_o set and no irq_o. reclaim_o pulses for one cycle if the wait was in link mode and stays low in pin mode. T=0 disables the timeout.
- R10: err_o stays set until the next accepted arm, which clears it.
- R11: refresh_start_o pulses together with irq_o if and only if auto_refresh_i was high when the wait was armed.
- R12: arm_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Start one tear wait (used only when idle) |
| link_mode_i | input | 1 | 1 = in-band trigger, 0 = pin trigger; sampled at arm |
| auto_refresh_i | input | 1 | Start the refresh sequencer on trigger; sampled at arm |
| fall_edge_i | input | 1 | Active pin edge: 0 rising, 1 falling |
| timeout_i | input | TIMER_W | Wait limit in cycles, 0 = none |
| te_pin_i | input | 1 | Asynchronous tear-effect pin from the display |
| cmd_req_o | output | 1 | Request to send the tear-enable command |
| cmd_opcode_o | output | 8 | Opcode of the requested command (0x35) |
| cmd_ack_i | input | 1 | Command path accepted the request |
| bta_req_o | output | 1 | One-cycle bus turnaround request |
| bus_peer_o | output | 1 | Display owns the link while the block waits |
| rx_valid_i | input | 1 | Received in-band byte valid |
| rx_byte_i | input | 8 | Received in-band byte |
| reclaim_o | output | 1 | One-cycle pulse to force the bus back after a timeout |
| irq_o | output | 1 | One-cycle interrupt pulse on trigger |
| refresh_start_o | output | 1 | One-cycle refresh launch pulse |
| err_o | output | 1 | Sticky timeout flag |
| busy_o | output | 1 | A wait is in progress |

## Verification
Several properties are checked on every cycle. They cover the command request holding until it is acknowledged, the single-cycle turnaround followed by bus ownership, the mutual exclusion of the three link-phase outputs, and irq_o always being a single pulse. They also confirm that a refresh launch never appears without an interrupt, that a reclaim always comes with the error flag, and that the edge detector never fires twice in a row for one polarity. Other behaviour needs stimulus and can only be shown by the bench's scenarios. This covers the exact length of the timeout window, the synchronizer latency, rejection of the wrong edge and of stray bytes, the order of arm and stale pin events, and the sticky error clearing only on the next arm.

// File: rtl/te_pkg.sv
package te_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_TURN,
    ST_LINK_WAIT,
    ST_PIN_WAIT
  } te_state_e;

  localparam logic [7:0] TEAR_ON_OPC = 8'h35;
  localparam logic [7:0] TRIG_CODE   = 8'hBA;
endpackage

// File: rtl/te_edge_sync.sv
module te_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else if (g == 0) sync_q[g] <= pin_i;
      else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign edge_o = fall_i ? (prev_q & ~sync_q[SYNC_STAGES-1])
                         : (~prev_q & sync_q[SYNC_STAGES-1]);

  // one polarity cannot fire on two consecutive cycles
  p_single_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && $stable(fall_i)) |=> !edge_o);
endmodule

// File: rtl/te_wait_timer.sv
module te_wait_timer #(
  parameter int TIMER_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [TIMER_W-1:0] limit_i,
  output logic               expire_o
);
  logic [TIMER_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (limit_i != '0) && (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/te_sync_ctrl.sv
module te_sync_ctrl
  import te_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               arm_i,
  input  logic               link_mode_i,
  input  logic               auto_refresh_i,
  input  logic               fall_edge_i,
  input  logic [TIMER_W-1:0] timeout_i,
  input  logic               te_pin_i,
  output logic               cmd_req_o,
  output logic [7:0]         cmd_opcode_o,
  input  logic               cmd_ack_i,
  output logic               bta_req_o,
  output logic               bus_peer_o,
  input  logic               rx_valid_i,
  input  logic [7:0]         rx_byte_i,
  output logic               reclaim_o,
  output logic               irq_o,
  output logic               refresh_start_o,
  output logic               err_o,
  output logic               busy_o
);
  te_state_e state_q, state_d;
  logic auto_q, irq_q, refresh_q, reclaim_q, err_q;
  logic pin_edge, expire, waiting, hit, timeout_ev, arm_ok;

  te_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (te_pin_i),
    .fall_i (fall_edge_i),
    .edge_o (pin_edge)
  );

  assign waiting = (state_q == ST_LINK_WAIT) || (state_q == ST_PIN_WAIT);

  te_wait_timer #(.TIMER_W(TIMER_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (waiting),
    .limit_i  (timeout_i),
    .expire_o (expire)
  );

  assign arm_ok     = (state_q == ST_IDLE) && arm_i;
  assign hit        = ((state_q == ST_LINK_WAIT) && rx_valid_i && (rx_byte_i == TRIG_CODE))
                   || ((state_q == ST_PIN_WAIT) && pin_edge);
  assign timeout_ev = waiting && !hit && expire;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (arm_i) state_d = link_mode_i ? ST_CMD : ST_PIN_WAIT;
      ST_CMD:       if (cmd_ack_i) state_d = ST_TURN;
      ST_TURN:      state_d = ST_LINK_WAIT;
      ST_LINK_WAIT,
      ST_PIN_WAIT:  if (hit || timeout_ev) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      auto_q    <= 1'b0;
      irq_q     <= 1'b0;
      refresh_q <= 1'b0;
      reclaim_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      irq_q     <= hit;
      refresh_q <= hit && auto_q;
      reclaim_q <= timeout_ev && (state_q == ST_LINK_WAIT);
      if (arm_ok) begin
        auto_q <= auto_refresh_i;
        err_q  <= 1'b0;
      end else if (timeout_ev) begin
        err_q  <= 1'b1;
      end
    end
  end

  assign cmd_req_o       = (state_q == ST_CMD);
  assign cmd_opcode_o    = TEAR_ON_OPC;
  assign bta_req_o       = (state_q == ST_TURN);
  assign bus_peer_o      = (state_q == ST_LINK_WAIT);
  assign busy_o          = (state_q != ST_IDLE);
  assign irq_o           = irq_q;
  assign refresh_start_o = refresh_q;
  assign reclaim_o       = reclaim_q;
  assign err_o           = err_q;

  p_cmd_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_o && !cmd_ack_i) |=> cmd_req_o);
  p_bta_then_peer_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bta_req_o |=> (!bta_req_o && bus_peer_o));
  p_link_phase_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_req_o, bta_req_o, bus_peer_o}));
  p_irq_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_refresh_needs_irq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_start_o |-> irq_o);
  p_reclaim_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reclaim_o |-> (err_o && !irq_o && !bus_peer_o));
endmodule

// File: tb/test_te_sync_ctrl.sv
module test_te_sync_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TW   = 16;
  localparam int SYNC = 2;

  logic clk = 0, rst_n = 0;
  logic arm = 0, link = 0, autor = 0, fall = 0, pin = 0, ack = 0, rxv = 0;
  logic [TW-1:0] tmo = '0;
  logic [7:0] rxb = '0;
  logic cmd_req, bta, peer, reclaim, irq, refr, err, busy;
  logic [7:0] opc;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  te_sync_ctrl #(.TIMER_W(TW), .SYNC_STAGES(SYNC)) i_te_sync_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .link_mode_i(link),
    .auto_refresh_i(autor), .fall_edge_i(fall), .timeout_i(tmo), .te_pin_i(pin),
    .cmd_req_o(cmd_req), .cmd_opcode_o(opc), .cmd_ack_i(ack), .bta_req_o(bta),
    .bus_peer_o(peer), .rx_valid_i(rxv), .rx_byte_i(rxb), .reclaim_o(reclaim),
    .irq_o(irq), .refresh_start_o(refr), .err_o(err), .busy_o(busy));

  function automatic int pin_latency();
    return SYNC + 1;
  endfunction

  function automatic logic [7:0] noise_byte();
    logic [7:0] b = 8'($urandom_range(0, 255));
    return (b == 8'hBA) ? 8'hB9 : b;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_arm(input bit lm, input bit au, input bit fe, input int t);
    link = lm; autor = au; fall = fe; tmo = TW'(t); arm = 1;
    step(); arm = 0;
    chk(busy, "R12 busy after arm", busy, 1);
    chk(!err, "R10 err cleared by arm", err, 0);
  endtask

  task automatic link_run(input bit au, input int t, input int noise, input bit late_arm);
    do_arm(1, au, $urandom_range(0, 1), t);
    chk(cmd_req && opc == 8'h35, "R2 tear-on request", opc, 8'h35);
    for (int i = 0; i < int'($urandom_range(0, 3)); i++) begin
      step();
      chk(cmd_req, "R2 request held", cmd_req, 1);
    end
    ack = 1; step(); ack = 0;
    chk(bta && !cmd_req && !peer, "R3 turnaround pulse", bta, 1);
    step();
    chk(!bta && peer, "R3 peer owns bus", {bta, peer}, 1);
    if (late_arm) begin
      arm = 1; link = 0; pin = ~pin; step(); arm = 0;
      chk(peer && !cmd_req, "R12 arm ignored while busy", peer, 1);
      chk(!irq, "R8 pin edge ignored in link wait", irq, 0);
    end
    if (t != 0) begin
      int n = 0;
      while (peer && n < t + 5) begin n++; step(); end
      n += late_arm ? 1 : 0;
      chk(n == t, "R9 link timeout length", n, t);
      chk(reclaim && err && !irq, "R9 reclaim on timeout", {reclaim, err, irq}, 6);
      step();
      chk(!reclaim && err, "R10 err sticky", {reclaim, err}, 1);
      return;
    end
    for (int i = 0; i < noise; i++) begin
      rxv = 1; rxb = noise_byte(); step(); rxv = 0;
      chk(peer && !irq, "R4 stray byte ignored", {peer, irq}, 2);
    end
    rxv = 0; rxb = 8'hBA; step();
    chk(peer && !irq, "R4 invalid trigger ignored", {peer, irq}, 2);
    rxv = 1; step(); rxv = 0;
    chk(irq && !peer && !busy, "R5 irq on trigger", {irq, peer, busy}, 4);
    chk(refr == au, "R11 refresh follows auto", refr, au);
    step();
    chk(!irq && !refr, "R5 irq one cycle", {irq, refr}, 0);
  endtask

  task automatic pin_run(input bit au, input bit fe, input int t);
    logic idle_lvl = fe;
    pin = ~idle_lvl;  // active edge while idle
    repeat (5) step();
    chk(!irq && !busy, "R8 edge ignored when idle", irq, 0);
    do_arm(0, au, fe, t);
    chk(!cmd_req && !bta && !peer, "R6 no link traffic", {cmd_req, bta, peer}, 0);
    if (t != 0) begin
      int n = 1;
      step();
      while (busy && n < t + 5) begin n++; step(); end
      chk(n == t, "R9 pin timeout length", n, t);
      chk(err && !reclaim && !irq, "R9 pin timeout no reclaim", {err, reclaim, irq}, 4);
      return;
    end
    pin = idle_lvl;  // opposite edge
    repeat (5) begin
      step();
      chk(!irq && busy, "R7 opposite edge ignored", irq, 0);
    end
    pin = ~idle_lvl;
    begin
      int k = 0;
      do begin step(); k++; end while (!irq && k < 10);
      chk(k == pin_latency(), "R6 pin latency", k, pin_latency());
      chk(refr == au && !busy, "R11 pin refresh", refr, au);
    end
    step();
    chk(!irq, "R5 pin irq one cycle", irq, 0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) step();
    chk({busy, cmd_req, bta, peer, irq, refr, reclaim, err} == 0, "R1 reset state",
        {busy, cmd_req, bta, peer, irq, refr, reclaim, err}, 0);
    rst_n = 1;
    step();
    chk(!busy && !err, "R1 idle after reset", busy, 0);
    link_run(1, 0, 2, 0);
    link_run(0, 0, 0, 1);
    link_run(1, 1, 0, 0);
    link_run(0, 7, 0, 1);
    pin_run(1, 0, 0);
    pin_run(0, 1, 0);
    pin_run(0, 0, 1);
    pin_run(1, 1, 9);
    for (int it = 0; it < 30; it++) begin
      int t = ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 12)) : 0;
      if ($urandom_range(0, 1) != 0)
        link_run($urandom_range(0, 1), t, $urandom_range(0, 4), $urandom_range(0, 1));
      else
        pin_run($urandom_range(0, 1), $urandom_range(0, 1), t);
      repeat ($urandom_range(0, 3)) step();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule